// File: doc/BRIEF.md
# Cascaded Real-Time Counter with Shared Interrupt Node

The block is a real-time counter built as a chain of three 16-bit stages. The first stage is a prescaler timer with its own reload register. It advances once for every cycle in which the tick enable is high. When it wraps, it reloads and passes one count into a low count stage, and the low stage passes its own wrap into a high count stage. Software reads and writes every stage, the reload value and the interrupt control through a small register bus. Reads are combinational. Writes land at the next clock edge. The stages are separate registers, so a multi-register read or write must allow for carries that happen between accesses.

A prescaler wrap sets a counter request flag in a subnode control register. The same register holds a second request flag, set by an external fault input, and one enable bit for each source. The two enabled requests share one interrupt node. A rising edge on their combined level sets the node request. The interrupt controller's acknowledge clears the node request. The subnode flags stay set until software clears them.

Top module: `rtc_chain_irq`

## Requirements
- R1: After reset every register reads zero, both subnode enables and the node enable are clear, and `irq_out` is low.
- R2: The prescaler (address 0) increments by one on each clock edge where `tick_en` is high, and holds its value when `tick_en` is low.
- R3: When `tick_en` is high and the prescaler holds FFFFh, it loads the reload register (address 1) at that edge, adds one to the low count (address 2), and sets the counter request flag (bit 0 of address 4).
- R4: A carry into the low count while it holds FFFFh wraps it to 0000h and adds one to the high count (address 3). The low count changes only on a carry or a write.
- R5: A bus write to any register takes effect at the next edge. If a carry arrives in the same cycle at a stage being written, the written value is kept, the carry is lost, and that stage passes no carry on.
- R6: Address 4 holds the counter request in bit 0, the counter enable in bit 1, the external request in bit 2 and the external enable in bit 3. Hardware never clears a request bit. A write to address 4 takes priority over a hardware set in the same cycle, and writing 1 to a request bit sets it.
- R7: A high level on `ext_src` at a clock edge sets the external request flag (bit 2 of address 4).
- R8: Address 5 holds the node request in bit 0 and the node enable in bit 1. The node request is set one edge after the value of (counter request AND counter enable) OR (external request AND external enable) rises. `irq_out` is high only while both the node request and the node enable are set.
- R9: `irq_ack` high at an edge clears the node request and leaves the subnode flags unchanged. The node request falls only on an acknowledge or a write to address 5.
- R10: A set request flag whose subnode enable is clear does not set the node request.
- R11: Reads of addresses 0 to 5 return the registers above. Addresses 6 and 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | Count enable for the prescaler |
| ext_src | input | 1 | Second interrupt source, level-sampled |
| irq_ack | input | 1 | Acknowledge from the interrupt controller |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| irq_out | output | 1 | Node interrupt request |

## Verification
The counter chain is driven with short tick bursts from a mid-range value, which separates plain incrementing from the wrap and reload. A double wrap from FFFFh in both the prescaler and the low stage shows that the carry ripples into the high stage in a single edge. A tick and a low-stage write in the same cycle show that the write is kept and the carry is lost. The interrupt path is driven with the counter source, the external source, software sets and acknowledges, each with the enables on and off. These patterns separate edge detection, gating by the enables, sticky subnode flags and the hardware clear of the node request.

// File: rtl/rtc_pkg.sv
`timescale 1ns/1ps
package rtc_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_PRE     = 3'd0,
    A_RELOAD  = 3'd1,
    A_LOW     = 3'd2,
    A_HIGH    = 3'd3,
    A_SUBCTL  = 3'd4,
    A_NODECTL = 3'd5
  } rtc_addr_e;

  // subnode control bit positions
  localparam int SB_RTC_REQ = 0;
  localparam int SB_RTC_EN  = 1;
  localparam int SB_EXT_REQ = 2;
  localparam int SB_EXT_EN  = 3;
  localparam int SB_W       = 4;

  // node control bit positions
  localparam int NB_REQ = 0;
  localparam int NB_EN  = 1;
  localparam int NB_W   = 2;
endpackage

// File: rtl/rtc_prescaler.sv
`timescale 1ns/1ps
module rtc_prescaler #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         wr_cnt,
  input  logic         wr_rel,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cnt,
  output logic [W-1:0] reload,
  output logic         ovf
);
  logic [W-1:0] cnt_d;
  logic         cnt_en;
  logic [W-1:0] reload_d;
  logic         reload_en;

  assign ovf = tick & (&cnt) & ~wr_cnt;

  always_comb begin
    cnt_en = wr_cnt | tick;
    if (wr_cnt)   cnt_d = wdata;
    else if (ovf) cnt_d = reload;
    else          cnt_d = cnt + W'(1);
    reload_en = wr_rel;
    reload_d  = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      reload <= '0;
    end else begin
      if (cnt_en)    cnt    <= cnt_d;
      if (reload_en) reload <= reload_d;
    end
  end
endmodule

// File: rtl/rtc_count_stage.sv
`timescale 1ns/1ps
module rtc_count_stage #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cin,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cnt,
  output logic         cout
);
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  assign cout = cin & (&cnt) & ~wr;

  always_comb begin
    cnt_en = wr | cin;
    cnt_d  = wr ? wdata : cnt + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_d;
  end
endmodule

// File: rtl/rtc_irq_subnode.sv
`timescale 1ns/1ps
module rtc_irq_subnode
  import rtc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rtc_set,
  input  logic            ext_set,
  input  logic            irq_ack,
  input  logic            sub_wr,
  input  logic [SB_W-1:0] sub_wdata,
  input  logic            node_wr,
  input  logic [NB_W-1:0] node_wdata,
  output logic [SB_W-1:0] sub_q,
  output logic [NB_W-1:0] node_q,
  output logic            irq
);
  logic [SB_W-1:0] sub_d;
  logic [NB_W-1:0] node_d;
  logic            comb_lvl;
  logic            comb_q;
  logic            comb_rise;

  always_comb begin
    comb_lvl  = (sub_q[SB_RTC_REQ] & sub_q[SB_RTC_EN]) |
                (sub_q[SB_EXT_REQ] & sub_q[SB_EXT_EN]);
    comb_rise = comb_lvl & ~comb_q;

    sub_d = sub_q;
    if (sub_wr) begin
      sub_d = sub_wdata;
    end else begin
      if (rtc_set) sub_d[SB_RTC_REQ] = 1'b1;
      if (ext_set) sub_d[SB_EXT_REQ] = 1'b1;
    end

    node_d = node_q;
    if (node_wr)        node_d = node_wdata;
    else if (comb_rise) node_d[NB_REQ] = 1'b1;
    else if (irq_ack)   node_d[NB_REQ] = 1'b0;
  end

  assign irq = node_q[NB_REQ] & node_q[NB_EN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q  <= '0;
      node_q <= '0;
      comb_q <= 1'b0;
    end else begin
      sub_q  <= sub_d;
      node_q <= node_d;
      comb_q <= comb_lvl;
    end
  end
endmodule

// File: rtl/rtc_chain_irq.sv
`timescale 1ns/1ps
module rtc_chain_irq
  import rtc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              ext_src,
  input  logic              irq_ack,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              irq_out
);
  localparam int NSTAGE = 2;

  // reset: asynchronous assert, synchronous release
  logic rst_meta;
  logic rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic             wr_pre, wr_rel, wr_sub, wr_node;
  logic [NSTAGE-1:0] wr_stage;
  logic [CNT_W-1:0] pre_cnt, pre_reload;
  logic             pre_ovf;
  logic [NSTAGE:0]  carry;
  logic [CNT_W-1:0] stage_cnt [NSTAGE];
  logic [CNT_W-1:0] low_cnt, high_cnt;
  logic [SB_W-1:0]  sub_q;
  logic [NB_W-1:0]  node_q;

  always_comb begin
    wr_pre  = bus_wr && (bus_addr == A_PRE);
    wr_rel  = bus_wr && (bus_addr == A_RELOAD);
    wr_sub  = bus_wr && (bus_addr == A_SUBCTL);
    wr_node = bus_wr && (bus_addr == A_NODECTL);
  end

  rtc_prescaler #(.W(CNT_W)) u_pre (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .tick   (tick_en),
    .wr_cnt (wr_pre),
    .wr_rel (wr_rel),
    .wdata  (bus_wdata),
    .cnt    (pre_cnt),
    .reload (pre_reload),
    .ovf    (pre_ovf)
  );

  assign carry[0] = pre_ovf;

  for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
    assign wr_stage[g] = bus_wr && (bus_addr == ADDR_W'(int'(A_LOW) + g));
    rtc_count_stage #(.W(CNT_W)) u_stage (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .cin   (carry[g]),
      .wr    (wr_stage[g]),
      .wdata (bus_wdata),
      .cnt   (stage_cnt[g]),
      .cout  (carry[g+1])
    );
  end

  assign low_cnt  = stage_cnt[0];
  assign high_cnt = stage_cnt[1];

  rtc_irq_subnode u_irq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .rtc_set    (pre_ovf),
    .ext_set    (ext_src),
    .irq_ack    (irq_ack),
    .sub_wr     (wr_sub),
    .sub_wdata  (bus_wdata[SB_W-1:0]),
    .node_wr    (wr_node),
    .node_wdata (bus_wdata[NB_W-1:0]),
    .sub_q      (sub_q),
    .node_q     (node_q),
    .irq        (irq_out)
  );

  always_comb begin
    unique case (bus_addr)
      A_PRE:     bus_rdata = pre_cnt;
      A_RELOAD:  bus_rdata = pre_reload;
      A_LOW:     bus_rdata = low_cnt;
      A_HIGH:    bus_rdata = high_cnt;
      A_SUBCTL:  bus_rdata = CNT_W'(sub_q);
      A_NODECTL: bus_rdata = CNT_W'(node_q);
      default:   bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/rtc_chain_irq_chk.sv
`timescale 1ns/1ps
module rtc_chain_irq_chk
  import rtc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              tick_en,
  input logic              irq_ack,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [CNT_W-1:0]  bus_wdata,
  input logic [CNT_W-1:0]  pre_cnt,
  input logic [CNT_W-1:0]  pre_reload,
  input logic [CNT_W-1:0]  low_cnt,
  input logic [SB_W-1:0]   sub_q,
  input logic [NB_W-1:0]   node_q
);
  logic wr_pre, wr_low, wr_sub, wr_node;
  assign wr_pre  = bus_wr && (bus_addr == A_PRE);
  assign wr_low  = bus_wr && (bus_addr == A_LOW);
  assign wr_sub  = bus_wr && (bus_addr == A_SUBCTL);
  assign wr_node = bus_wr && (bus_addr == A_NODECTL);

  // R3: wrap reloads and raises the counter request
  p_wrap_reload_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (tick_en && (&pre_cnt) && !wr_pre && !wr_sub) |=>
      (pre_cnt == $past(pre_reload)) && sub_q[SB_RTC_REQ]);

  // R4: the low stage moves only on a carry or a write
  p_low_hold_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!wr_low && !(tick_en && (&pre_cnt))) |=> $stable(low_cnt));

  // R5: a write to the low stage wins over any carry
  p_low_write_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_low |=> (low_cnt == $past(bus_wdata)));

  // R6: the counter request flag is sticky against hardware
  p_sticky_req_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sub_q[SB_RTC_REQ] && !wr_sub) |=> sub_q[SB_RTC_REQ]);

  // R9: the node request falls only on acknowledge or a software write
  p_node_fall_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(node_q[NB_REQ]) |-> ($past(irq_ack) || $past(wr_node)));
endmodule

bind rtc_chain_irq rtc_chain_irq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .tick_en    (tick_en),
  .irq_ack    (irq_ack),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .pre_cnt    (pre_cnt),
  .pre_reload (pre_reload),
  .low_cnt    (low_cnt),
  .sub_q      (sub_q),
  .node_q     (node_q)
);

// File: tb/rtc_chain_irq_tb.sv
`timescale 1ns/1ps
module rtc_chain_irq_tb;
  localparam logic [2:0] AD_PRE = 3'd0, AD_REL = 3'd1, AD_LOW = 3'd2,
                         AD_HIGH = 3'd3, AD_SUB = 3'd4, AD_NODE = 3'd5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        ext_src = 1'b0;
  logic        irq_ack = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic        irq_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // scoreboard queues: kind 0 = register read, kind 1 = irq pin
  int          q_kind [$];
  logic [15:0] q_exp  [$];
  string       q_tag  [$];

  always #4 clk = ~clk;

  rtc_chain_irq u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .ext_src   (ext_src),
    .irq_ack   (irq_ack),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out)
  );

  // monitor: compares after the driver has settled, away from the edge
  initial begin
    forever begin
      @(negedge clk);
      #3;
      while (q_kind.size() > 0) begin
        int          k;
        logic [15:0] e, a;
        string       t;
        k = q_kind.pop_front();
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        a = (k == 1) ? {15'h0, irq_out} : bus_rdata;
        checks++;
        if (a !== e) begin
          fails++;
          $display("FAIL %s: actual %h expected %h", t, a, e);
        end
      end
    end
  end

  task automatic chk_reg(input logic [2:0] a, input logic [15:0] e, input string t);
    @(negedge clk);
    bus_addr = a;
    q_kind.push_back(0);
    q_exp.push_back(e);
    q_tag.push_back(t);
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk);
    q_kind.push_back(1);
    q_exp.push_back({15'h0, e});
    q_tag.push_back(t);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic pulse_ack();
    @(negedge clk);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
  endtask

  task automatic pulse_ext();
    @(negedge clk);
    ext_src = 1'b1;
    @(negedge clk);
    ext_src = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 / R11: reset state and the full map
    for (int i = 0; i < 8; i++) chk_reg(3'(i), 16'h0, "R1");
    chk_irq(1'b0, "R1");

    // R2: counting and holding
    ticks(5);
    chk_reg(AD_PRE, 16'h0005, "R2");
    repeat (3) @(negedge clk);
    chk_reg(AD_PRE, 16'h0005, "R2 hold");

    // R3: wrap with reload, carry and request; R10: enables clear
    wr(AD_REL, 16'h1234);
    wr(AD_PRE, 16'hFFFD);
    ticks(3);
    chk_reg(AD_PRE, 16'h1234, "R3 reload");
    chk_reg(AD_LOW, 16'h0001, "R3 carry");
    chk_reg(AD_SUB, 16'h0001, "R3 request");
    chk_reg(AD_NODE, 16'h0000, "R10");
    chk_irq(1'b0, "R10");

    // R6: sticky, then software clear
    repeat (2) @(negedge clk);
    chk_reg(AD_SUB, 16'h0001, "R6 sticky");
    wr(AD_SUB, 16'h0000);
    chk_reg(AD_SUB, 16'h0000, "R6 clear");

    // R4: double wrap ripples into the high stage
    wr(AD_LOW, 16'hFFFF);
    wr(AD_HIGH, 16'h0000);
    wr(AD_PRE, 16'hFFFF);
    ticks(1);
    chk_reg(AD_PRE, 16'h1234, "R4");
    chk_reg(AD_LOW, 16'h0000, "R4 wrap");
    chk_reg(AD_HIGH, 16'h0001, "R4 high");

    // R5: write and carry in the same cycle, the write wins
    wr(AD_PRE, 16'hFFFF);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = AD_LOW; bus_wdata = 16'h0050; tick_en = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; tick_en = 1'b0;
    chk_reg(AD_LOW, 16'h0050, "R5 carry lost");
    chk_reg(AD_HIGH, 16'h0001, "R5 high");
    chk_reg(AD_PRE, 16'h1234, "R5 pre");

    // R6: software write beats a hardware set
    wr(AD_SUB, 16'h0000);
    wr(AD_PRE, 16'hFFFF);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = AD_SUB; bus_wdata = 16'h0000; tick_en = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; tick_en = 1'b0;
    chk_reg(AD_SUB, 16'h0000, "R6 write wins");
    chk_reg(AD_LOW, 16'h0051, "R6 carry");

    // R6 / R8: software set raises the node
    wr(AD_NODE, 16'h0002);
    wr(AD_SUB, 16'h0003);
    chk_reg(AD_NODE, 16'h0003, "R8 node set");
    chk_irq(1'b1, "R8 irq");

    // R9: acknowledge clears the node only
    pulse_ack();
    chk_reg(AD_NODE, 16'h0002, "R9 node clear");
    chk_reg(AD_SUB, 16'h0003, "R9 sub kept");
    chk_irq(1'b0, "R9 irq");

    // R7: external source
    wr(AD_SUB, 16'h0008);
    pulse_ext();
    chk_reg(AD_SUB, 16'h000C, "R7 ext flag");
    chk_reg(AD_NODE, 16'h0003, "R7 node");
    chk_irq(1'b1, "R7 irq");

    // R10: requests with enables clear stay quiet
    pulse_ack();
    wr(AD_SUB, 16'h0004);
    wr(AD_SUB, 16'h0001);
    repeat (2) @(negedge clk);
    chk_reg(AD_NODE, 16'h0002, "R10 gated");
    chk_irq(1'b0, "R10 irq");

    // R8: node request without node enable
    wr(AD_NODE, 16'h0001);
    chk_irq(1'b0, "R8 gate");
    chk_reg(AD_NODE, 16'h0001, "R8 node");

    // R11: reload readback and unmapped address
    chk_reg(AD_REL, 16'h1234, "R11 reload");
    chk_reg(3'd7, 16'h0000, "R11 unmapped");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule